// File: doc/BRIEF.md
# Multiplexed External Memory Bus Controller

This block runs external memory cycles for a small CPU core over one shared address/data bus. The core raises a one-cycle request that carries an address, write data, a byte/word size, a direction and an instruction-fetch flag. Each bus cycle puts the address on the bus with an address strobe, then moves data with read or write strobes and byte-lane selects, and then ends with a recovery cycle. The block returns read data together with a single done pulse.

Two configuration bits choose the bus width. The width can be fixed at 8 bits, fixed at 16 bits, or taken from a pin each time a request is accepted. A READY input adds wait states to the data phase, and a configured ceiling limits how many. A word access that does not fit the bus in one cycle becomes two byte cycles. Configuration inputs choose between a byte-high-enable lane select and separate high/low write strobes, and between a pulsed address latch and an address-valid level. Requests to internal memory complete at once, with no bus activity.

Top module: `ext_bus_ctrl`

## Requirements
- R1: `cfg_width_i` = 2'b01 gives 8-bit cycles and 2'b10 gives 16-bit cycles. With 2'b11, `bus_width_i` is sampled when a request is accepted (0 = 8-bit, 1 = 16-bit) and holds for every cycle of that access.
- R2: With `cfg_width_i` = 2'b00, `cfg_err_o` is 1, requests are ignored, `busy_o` stays 0 and no strobe moves.
- R3: An external bus cycle runs as one address cycle, then one or more data cycles, then one recovery cycle. `done_o` is high only in the recovery cycle of the last bus cycle of an access, and the block is idle in the next cycle.
- R4: `ready_i` is sampled at the clock edge that ends each data cycle. While it is low, the data phase repeats.
- R5: The data phase never lasts more than `cfg_max_wait_i`+1 cycles. At the ceiling it ends even if `ready_i` is low.
- R6: A request with `req_ext_i`=0 gives `done_o` in the cycle after acceptance, whatever `ready_i` is, with no strobe or bus drive.
- R7: With `cfg_lane_split_i`=0, `bhe_no` is active low during the address and data cycles of 16-bit cycles only:
  - Even-address byte: `bhe_no`=1, and the address on the bus has bit 0 = 0.
  - Odd-address byte: `bhe_no`=0, and address bit 0 = 1.
  - Aligned word: `bhe_no`=0, and address bit 0 = 0.

  On 8-bit cycles `bhe_no` stays 1.
- R8: With `cfg_lane_split_i`=1, on a 16-bit write cycle `wr_no` (low-lane write) falls only when the low byte is written, and `bhe_no` (high-lane write) falls only when the high byte is written. An aligned word write lowers both. On 8-bit writes `wr_no` falls and `bhe_no` stays 1.
- R9: With `cfg_lane_split_i`=0, `wr_no` is low in every data cycle of a write. In both lane modes, `rd_no` is low only in data cycles of a read.
- R10: `inst_o` is high in every cycle of an external read with `req_fetch_i`=1, from the address cycle through recovery. It is low otherwise, including for internal fetches.
- R11: With `cfg_addr_valid_i`=0, `addr_strobe_o` is a one-cycle high pulse in the address cycle. With `cfg_addr_valid_i`=1, it is low through the address and data cycles and high in recovery and idle.
- R12: A word access whose bus cycle is 8-bit, or whose address is odd, runs as two byte cycles, first at the request address and then at the address plus one. `done_o` is raised only in the second recovery cycle.
- R13: On 16-bit cycles, a byte travels on the high lane `[15:8]` when its address is odd and on the low lane otherwise; on 8-bit cycles it uses `[7:0]`. The unused lane is driven 0. Read data returns a byte zero-extended, and a split word returns with the first byte in `[7:0]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_width_i | input | 2 | Width mode select (bit1, bit0) |
| cfg_lane_split_i | input | 1 | 0: byte-high-enable, 1: split high/low write strobes |
| cfg_addr_valid_i | input | 1 | 0: pulsed address latch, 1: address-valid level |
| cfg_max_wait_i | input | WAIT_W | Wait-state ceiling |
| req_i | input | 1 | Access request, sampled while idle |
| req_ext_i | input | 1 | Access targets external memory |
| req_we_i | input | 1 | 1 = write |
| req_word_i | input | 1 | 1 = 16-bit access, 0 = byte |
| req_fetch_i | input | 1 | Access is an instruction fetch |
| req_addr_i | input | BUS_W | Byte address |
| req_wdata_i | input | BUS_W | Write data (byte in [7:0]) |
| bus_width_i | input | 1 | Per-access width pin |
| ready_i | input | 1 | Wait-state request, low stretches the data phase |
| ad_i | input | BUS_W | Bus read data |
| ad_o | output | BUS_W | Bus address/write data |
| ad_oe_o | output | 1 | Bus output enable |
| addr_strobe_o | output | 1 | Address latch pulse or address-valid level |
| rd_no | output | 1 | Read strobe, active low |
| wr_no | output | 1 | Write or low-lane write strobe, active low |
| bhe_no | output | 1 | High-byte enable or high-lane write strobe, active low |
| inst_o | output | 1 | Instruction fetch indicator |
| rdata_o | output | BUS_W | Read result |
| done_o | output | 1 | Access complete pulse |
| busy_o | output | 1 | Access in progress |
| cfg_err_o | output | 1 | Illegal width configuration |

## Verification
Two events can end the data phase in the same cycle: `ready_i` returning high and the wait counter reaching `cfg_max_wait_i`. The bench provokes this by holding `ready_i` low for exactly the ceiling count. The reference model then expects the recovery cycle to follow at once, with neither an extra wait nor an early exit. The bench also runs cases on either side of that boundary (fewer lows than the ceiling, and more), with zero wait states, and on both halves of a split word. At every clock it compares each strobe and the bus value against its model.

// File: rtl/ebc_pkg.sv
package ebc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_ADDR = 3'd1,
    ST_DATA = 3'd2,
    ST_REC  = 3'd3,
    ST_INT  = 3'd4
  } bus_state_e;

  // encoding is {W1, W2}
  typedef enum logic [1:0] {
    WM_BAD = 2'b00,
    WM_N8  = 2'b01,
    WM_N16 = 2'b10,
    WM_PIN = 2'b11
  } width_mode_e;
endpackage

// File: rtl/ebc_width_dec.sv
module ebc_width_dec
  import ebc_pkg::*;
(
  input  logic [1:0] mode_i,
  input  logic       pin_i,
  output logic       err_o,
  output logic       wide_o
);
  width_mode_e mode;
  assign mode = width_mode_e'(mode_i);

  always_comb begin
    err_o  = 1'b0;
    wide_o = 1'b0;
    case (mode)
      WM_N8:   wide_o = 1'b0;
      WM_N16:  wide_o = 1'b1;
      WM_PIN:  wide_o = pin_i;
      default: err_o  = 1'b1;
    endcase
  end
endmodule

// File: rtl/ebc_wait_ctr.sv
module ebc_wait_ctr #(
  parameter int WAIT_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              inc_i,
  input  logic [WAIT_W-1:0] limit_i,
  output logic              at_limit_o
);
  logic [WAIT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (inc_i)  cnt_q <= cnt_q + 1'b1;
  end

  assign at_limit_o = (cnt_q == limit_i);

  AST_WAIT_NO_PAST_LIMIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inc_i |-> !at_limit_o); // R5
endmodule

// File: rtl/ebc_lane_map.sv
module ebc_lane_map #(
  parameter int BUS_W = 16
) (
  input  logic             cyc16_i,
  input  logic             word_i,
  input  logic             addr0_i,
  input  logic             upper_i,
  input  logic [BUS_W-1:0] wdata_i,
  input  logic [BUS_W-1:0] rbus_i,
  output logic             hi_lane_o,
  output logic [BUS_W-1:0] wbus_o,
  output logic [BUS_W/2-1:0] rbyte_o
);
  localparam int LANE_W = BUS_W / 2;

  logic [LANE_W-1:0] wbyte;

  assign hi_lane_o = cyc16_i && !word_i && addr0_i;
  assign wbyte     = upper_i ? wdata_i[BUS_W-1:LANE_W] : wdata_i[LANE_W-1:0];

  always_comb begin
    if (word_i)         wbus_o = wdata_i;
    else if (hi_lane_o) wbus_o = {wbyte, {LANE_W{1'b0}}};
    else                wbus_o = {{LANE_W{1'b0}}, wbyte};
  end

  assign rbyte_o = hi_lane_o ? rbus_i[BUS_W-1:LANE_W] : rbus_i[LANE_W-1:0];
endmodule

// File: rtl/ebc_strobe_gen.sv
module ebc_strobe_gen
  import ebc_pkg::*;
(
  input  bus_state_e state_i,
  input  logic       we_i,
  input  logic       fetch_i,
  input  logic       cyc16_i,
  input  logic       word_i,
  input  logic       hi_lane_i,
  input  logic       lane_split_i,
  input  logic       addr_valid_i,
  output logic       addr_strobe_o,
  output logic       rd_no,
  output logic       wr_no,
  output logic       bhe_no,
  output logic       inst_o,
  output logic       ad_oe_o
);
  logic in_addr, in_data, in_rec, hi_used, lo_used;

  assign in_addr = (state_i == ST_ADDR);
  assign in_data = (state_i == ST_DATA);
  assign in_rec  = (state_i == ST_REC);
  assign hi_used = cyc16_i && (word_i || hi_lane_i);
  assign lo_used = !cyc16_i || word_i || !hi_lane_i;

  assign addr_strobe_o = addr_valid_i ? !(in_addr || in_data) : in_addr;
  assign rd_no         = !(in_data && !we_i);
  assign ad_oe_o       = in_addr || (in_data && we_i);
  assign inst_o        = (in_addr || in_data || in_rec) && fetch_i && !we_i;

  always_comb begin
    if (lane_split_i) begin
      wr_no  = !(in_data && we_i && lo_used);
      bhe_no = !(in_data && we_i && hi_used);
    end else begin
      wr_no  = !(in_data && we_i);
      bhe_no = !((in_addr || in_data) && hi_used);
    end
  end
endmodule

// File: rtl/ext_bus_ctrl.sv
module ext_bus_ctrl
  import ebc_pkg::*;
#(
  parameter int BUS_W  = 16,
  parameter int WAIT_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        cfg_width_i,
  input  logic              cfg_lane_split_i,
  input  logic              cfg_addr_valid_i,
  input  logic [WAIT_W-1:0] cfg_max_wait_i,
  input  logic              req_i,
  input  logic              req_ext_i,
  input  logic              req_we_i,
  input  logic              req_word_i,
  input  logic              req_fetch_i,
  input  logic [BUS_W-1:0]  req_addr_i,
  input  logic [BUS_W-1:0]  req_wdata_i,
  input  logic              bus_width_i,
  input  logic              ready_i,
  input  logic [BUS_W-1:0]  ad_i,
  output logic [BUS_W-1:0]  ad_o,
  output logic              ad_oe_o,
  output logic              addr_strobe_o,
  output logic              rd_no,
  output logic              wr_no,
  output logic              bhe_no,
  output logic              inst_o,
  output logic [BUS_W-1:0]  rdata_o,
  output logic              done_o,
  output logic              busy_o,
  output logic              cfg_err_o
);
  localparam int LANE_W = BUS_W / 2;

  bus_state_e        state_q;
  logic [BUS_W-1:0]  addr_q, wdata_q, rdata_q, wbus;
  logic              we_q, word_q, fetch_q, cyc16_q, split_q, part_q;
  logic              wide_now, cycle_word, hi_lane, at_limit, leave, last_part;
  logic [LANE_W-1:0] rbyte;

  ebc_width_dec u_width (
    .mode_i (cfg_width_i),
    .pin_i  (bus_width_i),
    .err_o  (cfg_err_o),
    .wide_o (wide_now)
  );

  ebc_wait_ctr #(.WAIT_W(WAIT_W)) u_wait (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_i      (state_q == ST_ADDR),
    .inc_i      ((state_q == ST_DATA) && !leave),
    .limit_i    (cfg_max_wait_i),
    .at_limit_o (at_limit)
  );

  assign cycle_word = word_q && !split_q;
  assign leave      = ready_i || at_limit;
  assign last_part  = !(split_q && !part_q);

  ebc_lane_map #(.BUS_W(BUS_W)) u_lane (
    .cyc16_i   (cyc16_q),
    .word_i    (cycle_word),
    .addr0_i   (addr_q[0]),
    .upper_i   (split_q && part_q),
    .wdata_i   (wdata_q),
    .rbus_i    (ad_i),
    .hi_lane_o (hi_lane),
    .wbus_o    (wbus),
    .rbyte_o   (rbyte)
  );

  ebc_strobe_gen u_strb (
    .state_i       (state_q),
    .we_i          (we_q),
    .fetch_i       (fetch_q),
    .cyc16_i       (cyc16_q),
    .word_i        (cycle_word),
    .hi_lane_i     (hi_lane),
    .lane_split_i  (cfg_lane_split_i),
    .addr_valid_i  (cfg_addr_valid_i),
    .addr_strobe_o (addr_strobe_o),
    .rd_no         (rd_no),
    .wr_no         (wr_no),
    .bhe_no        (bhe_no),
    .inst_o        (inst_o),
    .ad_oe_o       (ad_oe_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      addr_q  <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
      we_q    <= 1'b0;
      word_q  <= 1'b0;
      fetch_q <= 1'b0;
      cyc16_q <= 1'b0;
      split_q <= 1'b0;
      part_q  <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: if (req_i && !cfg_err_o) begin
          addr_q  <= req_addr_i;
          wdata_q <= req_wdata_i;
          we_q    <= req_we_i;
          word_q  <= req_word_i;
          fetch_q <= req_fetch_i && req_ext_i;
          cyc16_q <= wide_now;
          split_q <= req_word_i && (!wide_now || req_addr_i[0]);
          part_q  <= 1'b0;
          state_q <= req_ext_i ? ST_ADDR : ST_INT;
        end
        ST_ADDR: state_q <= ST_DATA;
        ST_DATA: if (leave) begin
          state_q <= ST_REC;
          if (!we_q) begin
            if (cycle_word)  rdata_q <= ad_i;
            else if (part_q) rdata_q[BUS_W-1:LANE_W] <= rbyte;
            else             rdata_q <= {{LANE_W{1'b0}}, rbyte};
          end
        end
        ST_REC: if (!last_part) begin
          part_q  <= 1'b1;
          addr_q  <= addr_q + 1'b1;
          state_q <= ST_ADDR;
        end else begin
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    if (state_q == ST_ADDR)                 ad_o = addr_q;
    else if (state_q == ST_DATA && we_q)    ad_o = wbus;
    else                                    ad_o = '0;
  end

  assign done_o  = ((state_q == ST_REC) && last_part) || (state_q == ST_INT);
  assign busy_o  = (state_q != ST_IDLE);
  assign rdata_o = rdata_q;

  AST_ERR_BLOCKS_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE && cfg_err_o) |=> (state_q == ST_IDLE)); // R2
  AST_DONE_AFTER_DATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && state_q == ST_REC) |-> ($past(state_q) == ST_DATA)); // R3
  AST_CEIL_ENDS_DATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_DATA && at_limit) |=> (state_q == ST_REC)); // R5
  AST_INT_NO_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_INT) |-> (rd_no && wr_no && !ad_oe_o)); // R6
  AST_BHE_QUIET_8BIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != ST_IDLE && !cyc16_q) |-> bhe_no); // R7
  AST_RD_WR_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!rd_no && !wr_no)); // R9
  AST_INST_READ_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inst_o |-> (!we_q && state_q != ST_INT)); // R10
  AST_SPLIT_FOLLOWS_REC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_ADDR && part_q) |-> ($past(state_q) == ST_REC)); // R12
endmodule

// File: tb/ext_bus_ctrl_bench.sv
module ext_bus_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WAIT_W = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] cfg_width = 2'b10;
  logic cfg_split = 1'b0, cfg_adv = 1'b0;
  logic [WAIT_W-1:0] cfg_max = 4'd3;
  logic req = 1'b0, req_ext = 1'b1, req_we = 1'b0, req_word = 1'b0, req_fetch = 1'b0;
  logic [15:0] req_addr = '0, req_wdata = '0, ad_in = '0;
  logic bw_pin = 1'b0, ready = 1'b1;
  logic [15:0] ad_out, rdata;
  logic ad_oe, astb, rd_n, wr_n, bhe_n, inst, done, busy, cerr;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ext_bus_ctrl #(.BUS_W(16), .WAIT_W(WAIT_W)) u_ext_bus_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .cfg_width_i(cfg_width), .cfg_lane_split_i(cfg_split),
    .cfg_addr_valid_i(cfg_adv), .cfg_max_wait_i(cfg_max), .req_i(req), .req_ext_i(req_ext),
    .req_we_i(req_we), .req_word_i(req_word), .req_fetch_i(req_fetch), .req_addr_i(req_addr),
    .req_wdata_i(req_wdata), .bus_width_i(bw_pin), .ready_i(ready), .ad_i(ad_in),
    .ad_o(ad_out), .ad_oe_o(ad_oe), .addr_strobe_o(astb), .rd_no(rd_n), .wr_no(wr_n),
    .bhe_no(bhe_n), .inst_o(inst), .rdata_o(rdata), .done_o(done), .busy_o(busy),
    .cfg_err_o(cerr)
  );

  // vector order: strobe, rd_n, wr_n, bhe_n, inst, oe, done
  task automatic chk_vec(input string tag, input logic [6:0] exp);
    logic [6:0] got;
    got = {astb, rd_n, wr_n, bhe_n, inst, ad_oe, done};
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s t=%0t strobes got=%b exp=%b", tag, $time, got, exp);
    end
  endtask

  task automatic chk_val(input string tag, input logic [15:0] got, input logic [15:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s t=%0t got=%h exp=%h", tag, $time, got, exp);
    end
  endtask

  task automatic idle_chk(input string tag);
    chk_vec(tag, {cfg_adv, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0});
  endtask

  // behavioural model of one external access, compared each clock
  task automatic ext_txn(input logic [15:0] a, input logic wide, input logic we,
                         input logic fetch, input logic bw, input int nlow,
                         input logic [15:0] wd, input logic [15:0] rv);
    logic is16;
    int parts, waits;
    logic [15:0] exp_rd;
    is16  = (cfg_width == 2'b11) ? bw : cfg_width[1];
    parts = (wide && (!is16 || a[0])) ? 2 : 1;
    waits = (nlow < int'(cfg_max)) ? nlow : int'(cfg_max);
    exp_rd = '0;
    @(negedge clk);
    req = 1'b1; req_ext = 1'b1; req_addr = a; req_word = wide; req_we = we;
    req_fetch = fetch; req_wdata = wd; bw_pin = bw; ready = 1'b0;
    @(negedge clk);
    req = 1'b0; bw_pin = ~bw; // width must stay as sampled (R1)
    for (int p = 0; p < parts; p++) begin
      logic [15:0] ca, wbus, rvp;
      logic cw, hi, bhe_a, insx, wrx, bhex;
      logic [7:0] bt, rb;
      ca    = a + 16'(p);
      cw    = wide && (parts == 1);
      hi    = is16 && !cw && ca[0];
      bt    = (parts == 2 && p == 1) ? wd[15:8] : wd[7:0];
      wbus  = cw ? wd : (hi ? {bt, 8'h00} : {8'h00, bt});
      rvp   = (p == 1) ? ~rv : rv;
      bhe_a = (!cfg_split && is16) ? !(cw || hi) : 1'b1;
      insx  = fetch && !we;
      // address cycle
      chk_vec("R11 R7 R10 R3", {!cfg_adv, 1'b1, 1'b1, bhe_a, insx, 1'b1, 1'b0});
      chk_val("R12 R7 address", ad_out, ca);
      @(negedge clk);
      for (int k = 0; k <= waits; k++) begin
        ready = (k < nlow) ? 1'b0 : 1'b1;
        ad_in = rvp;
        wrx  = !we ? 1'b1 : ((cfg_split && is16) ? !(cw || !hi) : 1'b0);
        bhex = cfg_split ? !(we && is16 && (cw || hi)) : bhe_a;
        chk_vec("R4 R5 R8 R9 R1", {1'b0, we, wrx, bhex, insx, we, 1'b0});
        if (we) chk_val("R13 write lane", ad_out, wbus);
        @(negedge clk);
      end
      rb = cw ? 8'h00 : (hi ? rvp[15:8] : rvp[7:0]);
      if (cw)          exp_rd = rvp;
      else if (p == 1) exp_rd[15:8] = rb;
      else             exp_rd = {8'h00, rb};
      ready = 1'b0;
      chk_vec("R3 R10 R12 recovery", {cfg_adv, 1'b1, 1'b1, 1'b1, insx, 1'b0, (p == parts - 1)});
      if (p == parts - 1 && !we) chk_val("R13 R12 read data", rdata, exp_rd);
      @(negedge clk);
    end
    idle_chk("R3 idle after done");
    ready = 1'b1;
  endtask

  task automatic int_txn(input logic we, input logic fetch);
    @(negedge clk);
    req = 1'b1; req_ext = 1'b0; req_we = we; req_fetch = fetch; ready = 1'b0;
    @(negedge clk);
    req = 1'b0;
    chk_vec("R6 R10 internal done", {cfg_adv, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1});
    @(negedge clk);
    idle_chk("R6 internal idle");
    req_ext = 1'b1; ready = 1'b1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    idle_chk("R3 reset state");
    chk_val("R2 reset err flag", {15'd0, cerr}, 16'd0);
    rst_n = 1'b1;

    // fixed 16-bit, byte-high-enable, latch pulse
    cfg_width = 2'b10; cfg_split = 1'b0; cfg_adv = 1'b0; cfg_max = 4'd3;
    ext_txn(16'h1000, 1'b0, 1'b0, 1'b0, 1'b0, 0, 16'h0000, 16'hA55A); // R7 low byte
    ext_txn(16'h1001, 1'b0, 1'b0, 1'b1, 1'b0, 1, 16'h0000, 16'hC33C); // R7 high byte, R10
    ext_txn(16'h2000, 1'b1, 1'b0, 1'b1, 1'b0, 0, 16'h0000, 16'h1234); // R7 both
    ext_txn(16'h2003, 1'b0, 1'b1, 1'b0, 1'b0, 0, 16'h00EE, 16'h0000); // R9 R13
    ext_txn(16'h2004, 1'b1, 1'b1, 1'b1, 1'b0, 2, 16'hBEEF, 16'h0000); // R4, fetch flag on write
    ext_txn(16'h2005, 1'b1, 1'b0, 1'b0, 1'b0, 0, 16'h0000, 16'h9876); // R12 odd word on 16
    // ceiling: below, equal, above
    ext_txn(16'h3000, 1'b0, 1'b0, 1'b0, 1'b0, 2, 16'h0, 16'h4411); // R4
    ext_txn(16'h3002, 1'b0, 1'b0, 1'b0, 1'b0, 3, 16'h0, 16'h4422); // R5 coincident
    ext_txn(16'h3004, 1'b0, 1'b0, 1'b0, 1'b0, 9, 16'h0, 16'h4433); // R5 capped
    cfg_max = 4'd0;
    ext_txn(16'h3006, 1'b1, 1'b1, 1'b0, 1'b0, 5, 16'h7788, 16'h0); // R5 no waits
    cfg_max = 4'd3;

    // fixed 8-bit, split write strobes, address-valid level
    cfg_width = 2'b01; cfg_split = 1'b1; cfg_adv = 1'b1;
    ext_txn(16'h4000, 1'b1, 1'b1, 1'b0, 1'b1, 1, 16'hCAFE, 16'h0); // R12 R8 R11
    ext_txn(16'h4011, 1'b0, 1'b1, 1'b0, 1'b1, 0, 16'h005A, 16'h0); // R8 on 8-bit
    ext_txn(16'h4021, 1'b1, 1'b0, 1'b1, 1'b1, 0, 16'h0, 16'hD00D); // R12 R10 read split

    // pin-selected width, split strobes on 16-bit
    cfg_width = 2'b11;
    ext_txn(16'h5000, 1'b1, 1'b1, 1'b0, 1'b1, 0, 16'h1357, 16'h0); // R1 R8 both strobes
    ext_txn(16'h5001, 1'b0, 1'b1, 1'b0, 1'b1, 0, 16'h0077, 16'h0); // R8 high only
    ext_txn(16'h5002, 1'b0, 1'b1, 1'b0, 1'b1, 0, 16'h0066, 16'h0); // R8 low only
    ext_txn(16'h5003, 1'b1, 1'b1, 1'b0, 1'b1, 1, 16'h2468, 16'h0); // R12 odd word
    ext_txn(16'h5004, 1'b1, 1'b0, 1'b0, 1'b0, 0, 16'h0, 16'hF00F); // R1 pin low, split
    cfg_adv = 1'b0; cfg_split = 1'b0;
    ext_txn(16'h5006, 1'b1, 1'b0, 1'b1, 1'b0, 2, 16'h0, 16'h0BAD); // R7 quiet on 8-bit

    // internal access ignores READY
    int_txn(1'b0, 1'b1); // R6 R10
    int_txn(1'b1, 1'b0); // R6

    // illegal width mode
    @(negedge clk);
    cfg_width = 2'b00;
    req = 1'b1; req_ext = 1'b1; req_we = 1'b0;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk_val("R2 error flag", {15'd0, cerr}, 16'd1);
      chk_val("R2 no start", {15'd0, busy}, 16'd0);
      idle_chk("R2 no strobes");
    end
    req = 1'b0;
    @(negedge clk);
    cfg_width = 2'b10;
    @(negedge clk);
    chk_val("R2 flag clears", {15'd0, cerr}, 16'd0);
    idle_chk("R2 still idle");

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule